// File: doc/BRIEF.md
# Latched-Address Single-Bit Multiplexer

This block routes one of up to sixteen single-bit inputs to a single output, chosen by a four-bit address. Two optional hold stages sit on the path. The first holds the address and the second holds the routed bit. Each stage has its own enable pin, and a parameter can remove either stage outright. When a stage is present, a parameter sets whether its enable acts as a level-sensitive transparent hold or as a rising-edge capture. The edge is detected on the clock.

Each data input can be inverted by a per-bit parameter mask before selection, and the output can be inverted by a parameter after the output hold stage. If the address names a lane at or beyond the implemented input count, the block routes a fixed default bit in place of any input. All state is clocked on one clock, with a synchronous active-low reset.

Top module: `bool_route_mux`

## Requirements
- R1: With both stages transparent, `dout` equals `din[addr]` XOR bit `addr` of `IN_INV`, then XOR `OUT_INV`, in the same cycle. The input mask is applied before selection.
- R2: In level mode of the address stage, the live address is used while `addr_hold_en` is 1. While it is 0, the address sampled at the last clock edge where the enable was 1 is used. After reset and before any such edge, that address is 0.
- R3: In level mode of the output stage, the routed bit passes while `out_hold_en` is 1. While it is 0, the bit sampled at the last clock edge where the enable was 1 is held.
- R4: An effective address greater than or equal to `N_IN` routes `DFLT_VAL`. `IN_INV` does not apply to it, and `OUT_INV` does.
- R5: A stage removed by parameter (`ADDR_HOLD` or `OUT_HOLD` = 0) is transparent. Its enable pin has no effect on `dout`.
- R6: In edge mode of the address stage, the address is captured at a clock edge where `addr_hold_en` is 1 and was 0 at the previous edge. The captured value takes effect after that edge and is held at all other times.
- R7: In edge mode of the output stage, the routed bit is captured at a clock edge where `out_hold_en` rises in the same sense as R6, and it is held at all other times.
- R8: Synchronous reset (`rst_n` = 0 at a clock edge) sets the held address to 0 and the held output bit to `DFLT_VAL`, and clears both edge detectors.
- R9: `OUT_INV` is applied after the output stage, so a held bit leaves inverted when `OUT_INV` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | N_IN | Single-bit data lanes |
| addr | input | 4 | Lane address |
| addr_hold_en | input | 1 | Enable of the address hold stage |
| out_hold_en | input | 1 | Enable of the output hold stage |
| dout | output | 1 | Routed, optionally held and inverted bit |

## Verification
On every cycle, the assertions check three things. While an enable is low, the effective address and the output do not move, in both level and edge mode. An out-of-range effective address always yields the default bit. A removed stage follows its input directly. The bench's scenarios are needed for the rest: the value that is captured on an enable fall or rise, the per-lane inversion pattern, the reset values, and the one-cycle delay before an edge-mode capture becomes visible. The bench runs three configurations side by side (level/level, edge/edge, and both stages removed) against a bench reference model.

// File: rtl/brm_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the latched-address multiplexer.
// Assumes at most sixteen data lanes; the address width covers all of them.
package brm_pkg;
    localparam int MAX_IN = 16;
    localparam int ADDR_W = $clog2(MAX_IN);

    typedef enum logic {
        CAP_LEVEL = 1'b0,
        CAP_EDGE  = 1'b1
    } cap_mode_e;
endpackage

// File: rtl/brm_hold_stage.sv
`timescale 1ns/1ps
// Optional hold stage for a W-bit value.
// HOLD_EN = 0: pure wire, enable ignored.
// Level mode: transparent while en is 1, holds the last passed value otherwise.
// Edge mode: captures d at a clock edge where en is 1 and was 0 at the prior
// edge; output is the captured register only.
// Assumes en is synchronous to clk.
module brm_hold_stage #(
    parameter int                 W       = 4,
    parameter bit                 HOLD_EN = 1'b1,
    parameter brm_pkg::cap_mode_e MODE    = brm_pkg::CAP_LEVEL,
    parameter logic [W-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (!HOLD_EN) begin : g_bypass
            logic unused_ctl;
            assign unused_ctl = ^{clk, rst_n, en};
            assign q = d;
        end else if (MODE == brm_pkg::CAP_LEVEL) begin : g_level
            logic [W-1:0] held_q;

            // Track the live value while enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)  held_q <= RST_VAL;
                else if (en) held_q <= d;
            end

            assign q = en ? d : held_q;
        end else begin : g_edge
            logic [W-1:0] held_q;
            logic         en_q;
            logic         rise;

            assign rise = en & ~en_q;

            // Remember enable and capture on its sampled rising edge.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    held_q <= RST_VAL;
                    en_q   <= 1'b0;
                end else begin
                    en_q <= en;
                    if (rise) held_q <= d;
                end
            end

            assign q = held_q;
        end
    endgenerate

endmodule

// File: rtl/brm_select.sv
`timescale 1ns/1ps
// Lane conditioning and selection.
// Applies the per-lane inversion mask, pads unimplemented lanes with the
// default bit, then picks one lane by address. Purely combinational.
module brm_select #(
    parameter int              N_IN     = 12,
    parameter logic [N_IN-1:0] IN_INV   = '0,
    parameter bit              DFLT_VAL = 1'b0
) (
    input  logic [N_IN-1:0]              din,
    input  logic [brm_pkg::ADDR_W-1:0]   addr,
    output logic                         sel
);
    localparam int LANES = brm_pkg::MAX_IN;

    logic [LANES-1:0] lanes;

    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            if (i < N_IN) begin : g_real
                assign lanes[i] = din[i] ^ IN_INV[i];
            end else begin : g_pad
                assign lanes[i] = DFLT_VAL;
            end
        end
    endgenerate

    assign sel = lanes[addr];

endmodule

// File: rtl/bool_route_mux.sv
`timescale 1ns/1ps
// Single-bit N-to-1 multiplexer with optional address and output hold stages.
// Path: addr -> address stage -> lane select (input mask, default for
// out-of-range) -> output stage -> output inversion -> dout.
// Assumes 2 <= N_IN <= 16 and all inputs synchronous to clk.
module bool_route_mux #(
    parameter int                 N_IN      = 12,
    parameter bit                 ADDR_HOLD = 1'b1,
    parameter brm_pkg::cap_mode_e ADDR_MODE = brm_pkg::CAP_LEVEL,
    parameter bit                 OUT_HOLD  = 1'b1,
    parameter brm_pkg::cap_mode_e OUT_MODE  = brm_pkg::CAP_LEVEL,
    parameter logic [N_IN-1:0]    IN_INV    = '0,
    parameter bit                 OUT_INV   = 1'b0,
    parameter bit                 DFLT_VAL  = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_IN-1:0]            din,
    input  logic [brm_pkg::ADDR_W-1:0] addr,
    input  logic                       addr_hold_en,
    input  logic                       out_hold_en,
    output logic                       dout
);
    localparam int AW = brm_pkg::ADDR_W;

    logic [AW-1:0] eff_addr;
    logic          routed;
    logic          held_bit;

    brm_hold_stage #(
        .W       (AW),
        .HOLD_EN (ADDR_HOLD),
        .MODE    (ADDR_MODE),
        .RST_VAL ('0)
    ) u_addr_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (addr_hold_en),
        .d     (addr),
        .q     (eff_addr)
    );

    brm_select #(
        .N_IN     (N_IN),
        .IN_INV   (IN_INV),
        .DFLT_VAL (DFLT_VAL)
    ) u_select (
        .din  (din),
        .addr (eff_addr),
        .sel  (routed)
    );

    brm_hold_stage #(
        .W       (1),
        .HOLD_EN (OUT_HOLD),
        .MODE    (OUT_MODE),
        .RST_VAL (DFLT_VAL)
    ) u_out_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (out_hold_en),
        .d     (routed),
        .q     (held_bit)
    );

    // Output polarity is applied after the hold stage.
    assign dout = held_bit ^ OUT_INV;

endmodule

// File: rtl/brm_checker.sv
`timescale 1ns/1ps
// Property checker for bool_route_mux, attached by bind.
// Observes ports plus the effective address and routed bit between stages.
module brm_checker #(
    parameter int                 N_IN      = 12,
    parameter bit                 ADDR_HOLD = 1'b1,
    parameter brm_pkg::cap_mode_e ADDR_MODE = brm_pkg::CAP_LEVEL,
    parameter bit                 OUT_HOLD  = 1'b1,
    parameter brm_pkg::cap_mode_e OUT_MODE  = brm_pkg::CAP_LEVEL,
    parameter bit                 OUT_INV   = 1'b0,
    parameter bit                 DFLT_VAL  = 1'b0
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [brm_pkg::ADDR_W-1:0] addr,
    input logic                       addr_hold_en,
    input logic                       out_hold_en,
    input logic [brm_pkg::ADDR_W-1:0] eff_addr,
    input logic                       routed,
    input logic                       dout
);

    AST_RANGE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_addr >= N_IN) |-> (routed == DFLT_VAL)); // R4

    generate
        if (!ADDR_HOLD) begin : g_a_byp
            AST_ADDR_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
                eff_addr == addr); // R5
        end else if (ADDR_MODE == brm_pkg::CAP_LEVEL) begin : g_a_lvl
            AST_ADDR_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !addr_hold_en |=> (addr_hold_en || $stable(eff_addr))); // R2
        end else begin : g_a_edg
            AST_ADDR_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !addr_hold_en |=> $stable(eff_addr)); // R6
        end

        if (!OUT_HOLD) begin : g_o_byp
            AST_OUT_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
                dout == (routed ^ OUT_INV)); // R5
        end else if (OUT_MODE == brm_pkg::CAP_LEVEL) begin : g_o_lvl
            AST_OUT_LEVEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !out_hold_en |=> (out_hold_en || $stable(dout))); // R3
        end else begin : g_o_edg
            AST_OUT_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !out_hold_en |=> $stable(dout)); // R7
        end
    endgenerate

endmodule

bind bool_route_mux brm_checker #(
    .N_IN      (N_IN),
    .ADDR_HOLD (ADDR_HOLD),
    .ADDR_MODE (ADDR_MODE),
    .OUT_HOLD  (OUT_HOLD),
    .OUT_MODE  (OUT_MODE),
    .OUT_INV   (OUT_INV),
    .DFLT_VAL  (DFLT_VAL)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr         (addr),
    .addr_hold_en (addr_hold_en),
    .out_hold_en  (out_hold_en),
    .eff_addr     (eff_addr),
    .routed       (routed),
    .dout         (dout)
);

// File: tb/bool_route_mux_tb.sv
`timescale 1ns/1ps
// Bench: three configurations (level/level, edge/edge, both removed) are
// driven with shared stimulus and compared against a reference model.
module bool_route_mux_tb;
    import brm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] din = '0;
    logic [3:0]  addr = '0;
    logic        a_en = 1'b0;
    logic        o_en = 1'b0;
    logic        d_lvl, d_edg, d_byp;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bool_route_mux #(
        .N_IN(12), .ADDR_HOLD(1'b1), .ADDR_MODE(CAP_LEVEL),
        .OUT_HOLD(1'b1), .OUT_MODE(CAP_LEVEL),
        .IN_INV(12'hA5C), .OUT_INV(1'b0), .DFLT_VAL(1'b1)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .din(din[11:0]), .addr(addr),
        .addr_hold_en(a_en), .out_hold_en(o_en), .dout(d_lvl)
    );

    bool_route_mux #(
        .N_IN(5), .ADDR_HOLD(1'b1), .ADDR_MODE(CAP_EDGE),
        .OUT_HOLD(1'b1), .OUT_MODE(CAP_EDGE),
        .IN_INV(5'h13), .OUT_INV(1'b1), .DFLT_VAL(1'b0)
    ) u_dut_edge (
        .clk(clk), .rst_n(rst_n), .din(din[4:0]), .addr(addr),
        .addr_hold_en(a_en), .out_hold_en(o_en), .dout(d_edg)
    );

    bool_route_mux #(
        .N_IN(16), .ADDR_HOLD(1'b0), .ADDR_MODE(CAP_LEVEL),
        .OUT_HOLD(1'b0), .OUT_MODE(CAP_LEVEL),
        .IN_INV(16'h00F0), .OUT_INV(1'b1), .DFLT_VAL(1'b1)
    ) u_dut_byp (
        .clk(clk), .rst_n(rst_n), .din(din), .addr(addr),
        .addr_hold_en(a_en), .out_hold_en(o_en), .dout(d_byp)
    );

    // Configuration table of the three instances.
    int          c_n    [3] = '{12, 5, 16};
    bit          c_ah   [3] = '{1'b1, 1'b1, 1'b0};
    bit          c_ae   [3] = '{1'b0, 1'b1, 1'b0};
    bit          c_oh   [3] = '{1'b1, 1'b1, 1'b0};
    bit          c_oe   [3] = '{1'b0, 1'b1, 1'b0};
    logic [15:0] c_inv  [3] = '{16'h0A5C, 16'h0013, 16'h00F0};
    bit          c_oinv [3] = '{1'b0, 1'b1, 1'b1};
    bit          c_dflt [3] = '{1'b1, 1'b0, 1'b1};
    string       c_name [3] = '{"level", "edge", "bypass"};

    // Reference model state.
    logic [3:0] m_ha  [3];
    logic       m_ho  [3];
    logic       m_eaq [3];
    logic       m_eoq [3];

    function automatic logic lane_val(int k, logic [3:0] a);
        if (int'(a) >= c_n[k]) return c_dflt[k];
        return din[a] ^ c_inv[k][a];
    endfunction

    function automatic logic [3:0] m_eff_addr(int k);
        if (!c_ah[k]) return addr;
        if (c_ae[k])  return m_ha[k];
        return a_en ? addr : m_ha[k];
    endfunction

    function automatic logic m_expect(int k);
        logic live;
        logic pre;
        live = lane_val(k, m_eff_addr(k));
        if (!c_oh[k])     pre = live;
        else if (c_oe[k]) pre = m_ho[k];
        else              pre = o_en ? live : m_ho[k];
        return pre ^ c_oinv[k];
    endfunction

    function automatic logic got(int k);
        case (k)
            0:       return d_lvl;
            1:       return d_edg;
            default: return d_byp;
        endcase
    endfunction

    task automatic model_clock();
        for (int k = 0; k < 3; k++) begin
            logic live;
            live = lane_val(k, m_eff_addr(k));
            if (!rst_n) begin
                m_ha[k]  = '0;
                m_ho[k]  = c_dflt[k];
                m_eaq[k] = 1'b0;
                m_eoq[k] = 1'b0;
            end else begin
                if (c_ae[k]) begin
                    if (a_en && !m_eaq[k]) m_ha[k] = addr;
                end else if (a_en) m_ha[k] = addr;
                if (c_oe[k]) begin
                    if (o_en && !m_eoq[k]) m_ho[k] = live;
                end else if (o_en) m_ho[k] = live;
                m_eaq[k] = a_en;
                m_eoq[k] = o_en;
            end
        end
    endtask

    // Drive one cycle, check all instances mid-cycle, then advance the model.
    task automatic step(input logic r, input logic [15:0] d, input logic [3:0] a,
                        input logic ea, input logic eo, input string req);
        @(negedge clk);
        rst_n = r; din = d; addr = a; a_en = ea; o_en = eo;
        #1;
        if (r) begin
            for (int k = 0; k < 3; k++) begin
                logic e;
                e = m_expect(k);
                checks++;
                if (got(k) !== e) begin
                    failures++;
                    $display("FAIL %s [%s] addr=%0d a_en=%0b o_en=%0b din=%h: got %0b expected %0b",
                             req, c_name[k], a, ea, eo, d, got(k), e);
                end
            end
        end
        @(posedge clk);
        model_clock();
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int k = 0; k < 3; k++) begin
            m_ha[k] = '0; m_ho[k] = c_dflt[k]; m_eaq[k] = 1'b0; m_eoq[k] = 1'b0;
        end

        // R8: reset state, enables low so held values appear at the output.
        repeat (3) step(1'b0, 16'hFFFF, 4'd9, 1'b0, 1'b0, "R8");
        step(1'b1, 16'h0000, 4'd7, 1'b0, 1'b0, "R8");
        step(1'b1, 16'hFFFF, 4'd2, 1'b0, 1'b0, "R8");

        // R1: transparent selection with input mask, several lanes and patterns.
        for (int i = 0; i < 12; i++) step(1'b1, 16'h3C96, 4'(i), 1'b1, 1'b1, "R1");
        for (int i = 0; i < 12; i++) step(1'b1, 16'hC369, 4'(i), 1'b1, 1'b1, "R1");

        // R2: address held after the enable falls.
        step(1'b1, 16'h0008, 4'd3, 1'b1, 1'b1, "R2");
        step(1'b1, 16'h0008, 4'd9, 1'b0, 1'b1, "R2");
        step(1'b1, 16'h0200, 4'd9, 1'b0, 1'b1, "R2");
        step(1'b1, 16'h0000, 4'd0, 1'b0, 1'b1, "R2");
        step(1'b1, 16'h0200, 4'd9, 1'b1, 1'b1, "R2");

        // R3: output bit held while its enable is low, data moving.
        step(1'b1, 16'h0020, 4'd5, 1'b1, 1'b1, "R3");
        step(1'b1, 16'h0000, 4'd5, 1'b1, 1'b0, "R3");
        step(1'b1, 16'hFFFF, 4'd1, 1'b1, 1'b0, "R3");
        step(1'b1, 16'h0000, 4'd1, 1'b1, 1'b1, "R3");

        // R4: out-of-range addresses route the default bit.
        for (int i = 12; i < 16; i++) step(1'b1, 16'hFFFF, 4'(i), 1'b1, 1'b1, "R4");
        step(1'b1, 16'h0000, 4'd6, 1'b0, 1'b0, "R4");
        step(1'b1, 16'h0000, 4'd6, 1'b1, 1'b0, "R4");
        step(1'b1, 16'hFFFF, 4'd6, 1'b1, 1'b1, "R4");
        step(1'b1, 16'hFFFF, 4'd6, 1'b1, 1'b1, "R4");

        // R6: edge capture of the address, no recapture while enable stays high.
        step(1'b1, 16'h0004, 4'd2, 1'b0, 1'b1, "R6");
        step(1'b1, 16'h0004, 4'd2, 1'b1, 1'b1, "R6");
        step(1'b1, 16'h0010, 4'd4, 1'b1, 1'b1, "R6");
        step(1'b1, 16'h0010, 4'd4, 1'b1, 1'b1, "R6");
        step(1'b1, 16'h0002, 4'd1, 1'b0, 1'b1, "R6");
        step(1'b1, 16'h0002, 4'd1, 1'b1, 1'b1, "R6");
        step(1'b1, 16'h0002, 4'd1, 1'b1, 1'b1, "R6");

        // R7: edge capture of the output bit.
        step(1'b1, 16'h0000, 4'd0, 1'b1, 1'b0, "R7");
        step(1'b1, 16'h0001, 4'd0, 1'b1, 1'b1, "R7");
        step(1'b1, 16'h0000, 4'd0, 1'b1, 1'b1, "R7");
        step(1'b1, 16'h0000, 4'd0, 1'b1, 1'b1, "R7");
        step(1'b1, 16'h0001, 4'd0, 1'b1, 1'b0, "R7");
        step(1'b1, 16'h0001, 4'd0, 1'b1, 1'b1, "R7");
        step(1'b1, 16'h0001, 4'd0, 1'b1, 1'b1, "R7");

        // R5: removed stages ignore enable toggling (bypass instance follows).
        for (int i = 0; i < 16; i++)
            step(1'b1, 16'h5A5A ^ 16'(i * 16'h1111), 4'(i), i[0], i[1], "R5");

        // R9: held bits leave through the output inversion.
        step(1'b1, 16'hFFFF, 4'd4, 1'b1, 1'b0, "R9");
        step(1'b1, 16'hFFFF, 4'd4, 1'b1, 1'b1, "R9");
        step(1'b1, 16'h0000, 4'd4, 1'b1, 1'b1, "R9");
        step(1'b1, 16'h0000, 4'd4, 1'b0, 1'b0, "R9");

        // Mid-run reset, then R8 values again.
        step(1'b0, 16'hFFFF, 4'd3, 1'b1, 1'b1, "R8");
        step(1'b1, 16'h0000, 4'd11, 1'b0, 1'b0, "R8");

        // Random mix of all behaviours (R1 R2 R3 R4 R6 R7 R9).
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            step(1'b1, 16'($urandom), r[3:0], r[4] | r[5], r[6] | r[7], "R1 R9 random");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule